// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability with Message Generator

This block holds the register set of a message-signalled interrupt capability and turns interrupt requests into single memory-write messages. Configuration software reaches the registers through a dword-wide write port with byte enables. Reads come back combinationally from the same dword index. Interrupt sources present a vector number with a valid/ready handshake. The block answers with one message, a 64-bit address and 32-bit data, on a second valid/ready handshake. Three elaboration parameters fix the layout: 64-bit addressing, per-vector masking, and the log2 of the number of vectors the function can use.

A vector that is masked is not lost. It is latched as a pending bit. A later write to the control word or the mask register, made while the capability is enabled, starts a replay. The replay discards pending bits outside the enabled range and then delivers every pending vector that is now unmasked, one at a time, lowest number first. The same write raises a one-cycle pulse that tells the legacy pin-based interrupt logic to drop its lines.

A sequencer with four named states drives the request and message sides. ST_IDLE accepts requests. When a request is unmasked and valid it moves to ST_DELIVER. When a qualifying write has flagged a replay it moves to ST_SCAN. ST_DELIVER holds the message and returns to ST_IDLE once the message is accepted. ST_SCAN finds the lowest deliverable pending vector, clears its pending bit and moves to ST_REPLAY_OUT. If no such vector exists it returns to ST_IDLE. ST_REPLAY_OUT holds the replayed message and returns to ST_SCAN once the message is accepted.

Top module: `sig_int_cap`

## Requirements
- R1: After reset, dword 0 bits 31:16 hold the control word. Its fields are: enable at bit 16, capable-count log2 at bits 19:17 (equal to CAP_LOG2), enabled-count log2 at bits 22:20, 64-bit flag at bit 23 (equal to ADDR64) and masking flag at bit 24 (equal to MASKING). After reset the enable bit and the enabled-count field are 0, bits 15:0 are 0, and every other register reads 0.
- R2: The register dwords are laid out as follows. Dword 1 holds the low address. With ADDR64 set, dword 2 holds the high address and dword 3 holds the data. Without ADDR64, dword 2 holds the data. A write changes only the bytes whose byte enable is set. In the control word only the enable bit and the enabled-count field are writable. Low-address bits 1:0 always read 0. The data register is 16 bits in bits 15:0, and bits 31:16 of that dword read 0.
- R3: With MASKING set, the mask register follows the data dword and the pending register follows the mask. Only the lowest 2^CAP_LOG2 mask bits are writable, and all other mask bits read 0.
- R4: An accepted request whose vector has its mask bit set sets that vector's pending bit and produces no message.
- R5: An accepted request for an in-range, unmasked vector produces a message one cycle after acceptance. Its address is {high address, low address}, with the high half zero when ADDR64 is clear. Its data is the zero-extended data register with its low F bits replaced by the vector number, where F is the enabled-count field.
- R6: A request accepted while the enable bit is 0, or with a vector at or above 2^F, produces no message and raises req_err for exactly the cycle after acceptance.
- R7: A control write that leaves the enable bit at 1 stores the enabled-count field clamped to at most CAP_LOG2.
- R8: A write that touches the control word or the mask register, and leaves the enable bit at 1, pulses intx_clr high for the one cycle after the write. Such writes made with the enable bit at 0 produce no pulse.
- R9: After such a qualifying write, pending bits at or above 2^F are cleared.
- R10: After a qualifying write, every pending and unmasked vector is delivered as a message, lowest vector first, one per message handshake, and its pending bit is cleared. req_ready stays low until the replay ends.
- R11: Dwords past the end of the capability read as 0. The pending register cannot be written.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Dword index within the capability |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| req_valid | input | 1 | Interrupt request valid |
| req_vec | input | 5 | Requested vector number |
| req_ready | output | 1 | Request may be accepted |
| req_err | output | 1 | One-cycle pulse on a dropped request |
| msg_valid | output | 1 | Message valid |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |
| msg_ready | input | 1 | Message accepted |
| intx_clr | output | 1 | One-cycle pulse forcing the legacy interrupt lines low |

## Verification
The assertions assume the following about the environment. Configuration writes and request acceptance never coincide; the block enforces this by lowering req_ready during a write. The message consumer may hold msg_ready low for any time. The address and data registers are not rewritten while a message is waiting, because the message is captured when it is launched.

The stimulus keeps within these rules. It issues writes only between handshakes and drives every input on the falling clock edge. It sweeps every enabled-count value, including one above the capable count, against every legal vector and two illegal ones.

// File: rtl/sig_int_pkg.sv
package sig_int_pkg;

    localparam int CFG_AW = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELIVER,
        ST_SCAN,
        ST_REPLAY_OUT
    } seq_state_t;

    // Replace the bytes selected by the enables.
    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return r;
    endfunction

    // Low-bit mask covering 2^lg vectors.
    function automatic logic [31:0] vec_span(input logic [2:0] lg);
        logic [5:0] n;
        n = 6'd1 << lg;
        return (n >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    // Zero-extended data with the low lg bits carrying the vector.
    function automatic logic [31:0] merge_data(input logic [15:0] d,
                                               input logic [2:0]  lg,
                                               input logic [4:0]  v);
        logic [31:0] m;
        m = (32'd1 << lg) - 32'd1;
        return ({16'd0, d} & ~m) | ({27'd0, v} & m);
    endfunction

endpackage

// File: rtl/sig_int_regs.sv
module sig_int_regs
    import sig_int_pkg::*;
#(
    parameter bit ADDR64   = 1'b1,
    parameter bit MASKING  = 1'b1,
    parameter int CAP_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              enable,
    output logic [2:0]        en_field,
    output logic [63:0]       msg_base,
    output logic [15:0]       data_reg,
    output logic [31:0]       mask_reg,
    output logic [31:0]       pend_reg,
    input  logic              set_pend,
    input  logic              clr_pend,
    input  logic [4:0]        pend_vec,
    output logic              kick,
    output logic              intx_clr
);
    localparam int          NVEC    = 1 << CAP_LOG2;
    localparam logic [31:0] MASK_WM = 32'hFFFF_FFFF >> (32 - NVEC);
    localparam logic [2:0]  CAP_F   = 3'(CAP_LOG2);
    localparam int          DW_DATA = ADDR64 ? 3 : 2;
    localparam int          DW_MASK = DW_DATA + 1;
    localparam int          DW_PEND = DW_DATA + 2;
    localparam int          DW_LAST = MASKING ? DW_PEND : DW_DATA;

    logic [29:0] addr_lo;
    logic [31:0] addr_hi;

    logic       wr_ctl, touch_ctl, touch_mask, qualify;
    logic       new_en;
    logic [2:0] raw_fld, new_fld;
    logic [31:0] ctl_word, pend_nx, mask_nx;

    assign ctl_word  = {7'd0, MASKING, ADDR64, en_field, CAP_F, enable, 16'd0};
    assign wr_ctl    = cfg_wr && (cfg_addr == '0) && cfg_be[2];
    assign touch_ctl = cfg_wr && (cfg_addr == '0) && (cfg_be[2] || cfg_be[3]);
    assign touch_mask = MASKING && cfg_wr && (int'(cfg_addr) == DW_MASK) && (cfg_be != 4'd0);
    assign new_en    = wr_ctl ? cfg_wdata[16] : enable;
    assign raw_fld   = wr_ctl ? cfg_wdata[22:20] : en_field;
    assign new_fld   = (new_en && (raw_fld > CAP_F)) ? CAP_F : raw_fld;
    assign qualify   = (touch_ctl || touch_mask) && new_en;
    assign kick      = qualify && MASKING;

    assign msg_base  = {addr_hi, addr_lo, 2'b00};

    always_comb begin
        mask_nx = mask_reg;
        if (touch_mask) mask_nx = be_merge(mask_reg, cfg_wdata, cfg_be) & MASK_WM;
        pend_nx = pend_reg;
        if (set_pend) pend_nx[pend_vec] = 1'b1;
        if (clr_pend) pend_nx[pend_vec] = 1'b0;
        if (qualify)  pend_nx = pend_nx & vec_span(new_fld);
        if (!MASKING) begin
            pend_nx = '0;
            mask_nx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            en_field <= '0;
            addr_lo  <= '0;
            data_reg <= '0;
            mask_reg <= '0;
            pend_reg <= '0;
            intx_clr <= 1'b0;
        end else begin
            intx_clr <= qualify;
            mask_reg <= mask_nx;
            pend_reg <= pend_nx;
            if (wr_ctl) begin
                enable   <= new_en;
                en_field <= new_fld;
            end
            if (cfg_wr && cfg_addr == 3'd1) begin
                addr_lo <= be_merge({addr_lo, 2'b00}, cfg_wdata, cfg_be) >> 2;
            end
            if (cfg_wr && int'(cfg_addr) == DW_DATA) begin
                data_reg <= be_merge({16'd0, data_reg}, cfg_wdata, cfg_be) & 32'h0000_FFFF;
            end
        end
    end

    generate
        if (ADDR64) begin : g_hi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_hi <= '0;
                end else if (cfg_wr && cfg_addr == 3'd2) begin
                    addr_hi <= be_merge(addr_hi, cfg_wdata, cfg_be);
                end
            end
        end else begin : g_no_hi
            assign addr_hi = '0;
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) <= DW_LAST) begin
            if (cfg_addr == '0)                  cfg_rdata = ctl_word;
            else if (cfg_addr == 3'd1)           cfg_rdata = {addr_lo, 2'b00};
            else if (int'(cfg_addr) == DW_DATA)  cfg_rdata = {16'd0, data_reg};
            else if (int'(cfg_addr) == DW_MASK)  cfg_rdata = mask_reg;
            else if (int'(cfg_addr) == DW_PEND)  cfg_rdata = pend_reg;
            else                                 cfg_rdata = addr_hi;
        end
    end

    // R7
    en_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (en_field <= CAP_F));

    // R3
    mask_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_reg & ~MASK_WM) == 32'd0);

    // R4
    pend_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_pend |-> mask_reg[pend_vec]);

endmodule

// File: rtl/sig_int_seq.sv
module sig_int_seq
    import sig_int_pkg::*;
#(
    parameter bit MASKING = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [4:0]  req_vec,
    output logic        req_ready,
    output logic        req_err,
    output logic        msg_valid,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    input  logic        msg_ready,
    input  logic        cfg_wr,
    input  logic        enable,
    input  logic [2:0]  en_field,
    input  logic [63:0] msg_base,
    input  logic [15:0] data_reg,
    input  logic [31:0] mask_reg,
    input  logic [31:0] pend_reg,
    input  logic        kick,
    output logic        set_pend,
    output logic        clr_pend,
    output logic [4:0]  pend_vec
);
    seq_state_t state, nxt;
    logic        replay_due;
    logic        accept, in_range, vec_ok, vec_masked, has_cand;
    logic [31:0] cand;
    logic [4:0]  pick;

    assign accept     = req_valid && req_ready;
    assign in_range   = ({4'd0, req_vec} < (9'd1 << en_field));
    assign vec_ok     = enable && in_range;
    assign vec_masked = MASKING && mask_reg[req_vec];
    assign cand       = pend_reg & ~mask_reg & vec_span(en_field);
    assign has_cand   = |cand;

    always_comb begin
        pick = '0;
        for (int i = 31; i >= 0; i--) begin
            if (cand[i]) pick = 5'(i);
        end
    end

    assign req_ready = (state == ST_IDLE) && !replay_due && !cfg_wr;
    assign msg_valid = (state == ST_DELIVER) || (state == ST_REPLAY_OUT);
    assign set_pend  = accept && vec_ok && vec_masked;
    assign clr_pend  = (state == ST_SCAN) && has_cand;
    assign pend_vec  = (state == ST_SCAN) ? pick : req_vec;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (replay_due)                          nxt = ST_SCAN;
                else if (accept && vec_ok && !vec_masked) nxt = ST_DELIVER;
            end
            ST_DELIVER:    if (msg_ready) nxt = ST_IDLE;
            ST_SCAN:       nxt = has_cand ? ST_REPLAY_OUT : ST_IDLE;
            ST_REPLAY_OUT: if (msg_ready) nxt = ST_SCAN;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            replay_due <= 1'b0;
            req_err    <= 1'b0;
            msg_addr   <= '0;
            msg_data   <= '0;
        end else begin
            req_err <= accept && !vec_ok;
            if (kick)                                  replay_due <= 1'b1;
            else if (state == ST_IDLE && replay_due)   replay_due <= 1'b0;
            if (state == ST_IDLE && !replay_due && accept && vec_ok && !vec_masked) begin
                msg_addr <= msg_base;
                msg_data <= merge_data(data_reg, en_field, req_vec);
            end else if (state == ST_SCAN && has_cand) begin
                msg_addr <= msg_base;
                msg_data <= merge_data(data_reg, en_field, pick);
            end
        end
    end

    // R12
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid && req_ready));

    // R10
    no_req_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !req_ready);

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[1:0] == 2'b00));

endmodule

// File: rtl/sig_int_cap.sv
module sig_int_cap
    import sig_int_pkg::*;
#(
    parameter bit ADDR64   = 1'b1,
    parameter bit MASKING  = 1'b1,
    parameter int CAP_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [4:0]        req_vec,
    output logic              req_ready,
    output logic              req_err,
    output logic              msg_valid,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data,
    input  logic              msg_ready,
    output logic              intx_clr
);
    logic        enable, kick, set_pend, clr_pend;
    logic [2:0]  en_field;
    logic [63:0] msg_base;
    logic [15:0] data_reg;
    logic [31:0] mask_reg, pend_reg;
    logic [4:0]  pend_vec;

    sig_int_regs #(
        .ADDR64   (ADDR64),
        .MASKING  (MASKING),
        .CAP_LOG2 (CAP_LOG2)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .enable    (enable),
        .en_field  (en_field),
        .msg_base  (msg_base),
        .data_reg  (data_reg),
        .mask_reg  (mask_reg),
        .pend_reg  (pend_reg),
        .set_pend  (set_pend),
        .clr_pend  (clr_pend),
        .pend_vec  (pend_vec),
        .kick      (kick),
        .intx_clr  (intx_clr)
    );

    sig_int_seq #(
        .MASKING (MASKING)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_vec   (req_vec),
        .req_ready (req_ready),
        .req_err   (req_err),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .msg_ready (msg_ready),
        .cfg_wr    (cfg_wr),
        .enable    (enable),
        .en_field  (en_field),
        .msg_base  (msg_base),
        .data_reg  (data_reg),
        .mask_reg  (mask_reg),
        .pend_reg  (pend_reg),
        .kick      (kick),
        .set_pend  (set_pend),
        .clr_pend  (clr_pend),
        .pend_vec  (pend_vec)
    );

endmodule

// File: tb/sig_int_cap_bench.sv
module sig_int_cap_bench;
    localparam bit ADDR64   = 1'b1;
    localparam bit MASKING  = 1'b1;
    localparam int CAP_LOG2 = 3;
    localparam logic [31:0] CTL_RST = (32'(MASKING) << 24) | (32'(ADDR64) << 23) | (32'(CAP_LOG2) << 17);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [4:0]  req_vec = '0;
    logic        req_ready, req_err, msg_valid, intx_clr;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        msg_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sig_int_cap #(.ADDR64(ADDR64), .MASKING(MASKING), .CAP_LOG2(CAP_LOG2)) u_sig_int_cap (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_vec(req_vec),
        .req_ready(req_ready), .req_err(req_err), .msg_valid(msg_valid), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_ready(msg_ready), .intx_clr(intx_clr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        #1;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Returns at the falling edge after the accepting rising edge.
    task automatic send_req(input logic [4:0] v);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_vec = v;
        #1;
        guard = 0;
        while (!req_ready && guard < 50) begin
            @(negedge clk); #1; guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic take_msg();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        #1;
    endtask

    task automatic wait_msg(output bit seen);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (msg_valid) begin seen = 1; break; end
            @(negedge clk); #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] base_d;
        logic [63:0] base_a;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset contents
        cfg_read(3'd0, rd); check("R1 ctl", rd, CTL_RST);
        for (int a = 1; a <= 5; a++) begin
            cfg_read(3'(a), rd); check("R1 reg", rd, 0);
        end
        check("R1 ready", req_ready, 1);
        check("R1 valid", msg_valid, 0);

        // R2: write masks and byte enables
        cfg_write(3'd0, 32'hFFFF_FFFF, 4'hF);
        cfg_read(3'd0, rd); check("R2 ctl mask", rd, CTL_RST | 32'h0001_0000 | (32'(CAP_LOG2) << 20));
        cfg_write(3'd1, 32'h9ABC_DEF3, 4'hF);
        cfg_read(3'd1, rd); check("R2 addr lo", rd, 32'h9ABC_DEF0);
        cfg_write(3'd2, 32'h1234_5678, 4'hF);
        cfg_read(3'd2, rd); check("R2 addr hi", rd, 32'h1234_5678);
        cfg_write(3'd3, 32'hFFFF_BEEF, 4'hF);
        cfg_read(3'd3, rd); check("R2 data", rd, 32'h0000_BEEF);
        cfg_write(3'd3, 32'h0000_0011, 4'h1);
        cfg_read(3'd3, rd); check("R2 data byte", rd, 32'h0000_BE11);
        cfg_write(3'd3, 32'h0000_BEEF, 4'h3);
        base_d = 32'h0000_BEEF;
        base_a = 64'h1234_5678_9ABC_DEF0;

        // R11: past-end reads and read-only pending
        cfg_read(3'd6, rd); check("R11 dw6", rd, 0);
        cfg_read(3'd7, rd); check("R11 dw7", rd, 0);
        cfg_write(3'd5, 32'hFFFF_FFFF, 4'hF);
        cfg_read(3'd5, rd); check("R11 pend ro", rd, 0);

        // R3: mask span
        cfg_write(3'd4, 32'hFFFF_FFFF, 4'hF);
        cfg_read(3'd4, rd); check("R3 mask span", rd, 32'h0000_00FF);
        cfg_write(3'd4, 32'h0, 4'hF);

        // R5 R6 R7: sweep of enabled-count field and vectors
        for (int f = 0; f <= 4; f++) begin
            int fe;
            fe = (f > CAP_LOG2) ? CAP_LOG2 : f;
            cfg_write(3'd0, (32'(f) << 20) | 32'h0001_0000, 4'h4);
            cfg_read(3'd0, rd); check("R7 clamp", 64'(rd[22:20]), 64'(fe));
            for (int vi = 0; vi < 10; vi++) begin
                int v;
                logic [31:0] m;
                v = (vi < 8) ? vi : ((vi == 8) ? 8 : 31);
                send_req(5'(v));
                if (v < (1 << fe)) begin
                    m = (32'd1 << fe) - 1;
                    check("R5 valid", msg_valid, 1);
                    check("R6 no err", req_err, 0);
                    check("R5 addr", msg_addr, base_a);
                    check("R5 data", msg_data, (base_d & ~m) | (32'(v) & m));
                    if (v == 0) begin
                        repeat (2) @(negedge clk);
                        #1;
                        check("R12 hold valid", msg_valid, 1);
                        check("R12 hold data", msg_data, base_d & ~m);
                    end
                    take_msg();
                end else begin
                    check("R6 err", req_err, 1);
                    check("R6 no msg", msg_valid, 0);
                    @(negedge clk); #1;
                    check("R6 err pulse", req_err, 0);
                end
            end
        end

        // R4 R10: mask, capture pending, replay in order
        cfg_write(3'd0, (32'd3 << 20) | 32'h0001_0000, 4'h4);
        cfg_write(3'd4, 32'h0000_00FF, 4'hF);
        send_req(5'd5); check("R4 no msg", msg_valid, 0);
        send_req(5'd2);
        send_req(5'd7);
        cfg_read(3'd5, rd); check("R4 pend", rd, 32'h0000_00A4);
        cfg_write(3'd4, 32'h0, 4'hF);
        check("R8 pulse mask", intx_clr, 1);
        for (int k = 0; k < 3; k++) begin
            int ev;
            ev = (k == 0) ? 2 : ((k == 1) ? 5 : 7);
            wait_msg(seen);
            check("R10 replay seen", seen, 1);
            check("R10 replay data", msg_data, 32'h0000_BEE8 | 32'(ev));
            check("R10 ready low", req_ready, 0);
            take_msg();
        end
        repeat (3) @(negedge clk);
        #1;
        check("R10 no more", msg_valid, 0);
        cfg_read(3'd5, rd); check("R10 pend clear", rd, 0);
        check("R10 ready back", req_ready, 1);

        // R9: trim pending above enabled count
        cfg_write(3'd4, 32'h0000_00FF, 4'hF);
        send_req(5'd6);
        send_req(5'd1);
        cfg_read(3'd5, rd); check("R9 pend set", rd, 32'h0000_0042);
        cfg_write(3'd0, (32'd1 << 20) | 32'h0001_0000, 4'h4);
        check("R8 pulse ctl", intx_clr, 1);
        @(negedge clk); #1;
        check("R8 pulse end", intx_clr, 0);
        cfg_read(3'd5, rd); check("R9 trimmed", rd, 32'h0000_0002);

        // R8: no pulse while disabled
        cfg_write(3'd0, 32'h0, 4'h4);
        check("R8 disable no pulse", intx_clr, 0);
        cfg_write(3'd4, 32'h0, 4'hF);
        check("R8 mask no pulse", intx_clr, 0);
        repeat (3) @(negedge clk);
        #1;
        check("R8 no replay disabled", msg_valid, 0);
        send_req(5'd0);
        check("R6 disabled err", req_err, 1);
        check("R6 disabled no msg", msg_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule